// File: doc/BRIEF.md
# Receive Page Allocator

This block gives packet memory to incoming frames one page at a time while each frame is still arriving. When a frame starts and reception is enabled, the block takes the lowest-numbered free page from a pool that a bitmap tracks. The index of that first page becomes the frame's packet number. Each received word is written at the next sequential logical address. That logical address is translated to a physical address made of the page index and the word offset within the page. When a word crosses into a new page, the block takes another free page and links it after the previous one in a table of next-pointers.

If a page is needed and none is free, the frame is dropped. Every page the frame already holds goes back to the pool in one step, and the rest of the frame is ignored until its last word. A frame that completes normally places its packet number in a completion queue, and a receive interrupt stays high while that queue holds entries. Software walks a packet's pages through the next-pointer lookup port and returns pages to the pool through the release port.

Top module: `rx_page_alloc`

## Requirements
- R1: While `rxEnable` is low, `frameStart` is ignored: no page is taken, and no word of that frame is written (`memWrEn` stays low).
- R2: An accepted frame start takes the lowest-numbered free page. The packet number reported for the frame equals that page's index.
- R3: The words of an accepted frame are written in arrival order at logical addresses 0, 1, 2, … on `memLogAddr`. `memData` carries `wordData` unchanged.
- R4: The physical write address is `{page, offset}`. The page index fills the upper `log2(PAGES)` bits and the offset (logical address modulo `WORDS_PER_PAGE`) fills the lower `log2(WORDS_PER_PAGE)` bits.
- R5: When a word's logical address is a nonzero multiple of `WORDS_PER_PAGE`, the lowest-numbered free page is taken and that word is written at its offset 0.
- R6: `lookupNext` for each page of a frame gives the frame's following page. `lookupHasNext` is 1 on every page except the last, where it is 0.
- R7: If a page is needed and none is free (at frame start or at a page boundary), `dropPulse` is high for that cycle and the word is not written. No word up to and including the frame's last word is written. Every page the frame held returns to the pool, and no completion entry is made.
- R8: Each normally completed frame adds its packet number to the completion queue, in completion order. `doneValid` and `rxIrq` are high while the queue is non-empty, `donePkt` shows the oldest entry, and `donePop` removes it.
- R9: A pulse on `relValid` returns page `relPage` to the pool, where later allocations can take it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Reception enable; gates frame acceptance |
| frameStart | input | 1 | Address-matched frame begins |
| wordValid | input | 1 | A receive word is present |
| wordLast | input | 1 | Present word is the frame's last |
| wordData | input | DATA_W | Receive word |
| relValid | input | 1 | Return a page to the pool |
| relPage | input | log2(PAGES) | Page to return |
| lookupPage | input | log2(PAGES) | Page whose link is queried |
| lookupNext | output | log2(PAGES) | Following page of `lookupPage` |
| lookupHasNext | output | 1 | `lookupPage` has a following page |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | log2(PAGES)+log2(WORDS_PER_PAGE) | Physical write address |
| memData | output | DATA_W | Write data |
| memLogAddr | output | log2(PAGES)+log2(WORDS_PER_PAGE)+1 | Logical address of the write |
| dropPulse | output | 1 | Frame dropped for lack of memory |
| doneValid | output | 1 | Completion queue non-empty |
| donePkt | output | log2(PAGES) | Oldest completed packet number |
| donePop | input | 1 | Remove oldest completion entry |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with four pages of four words each, so a frame of 17 words needs more memory than the whole pool holds. With this configuration the bench sweeps every frame length from one word to 17, which covers each page-boundary position, a frame that uses the full pool and an overrun at the final boundary. Exhausting the pool, fragmenting it through releases, overrunning at frame start and overrunning in the middle of a frame each take only a few dozen cycles. The bench predicts every physical address, packet number and link from its own lowest-free model of the pool.

// File: rtl/rx_pg_pkg.sv
package rx_pg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DROP   = 2'd2
  } rxState_e;

  typedef struct packed {
    logic startFrame;
    logic writeWord;
    logic allocNext;
    logic commit;
    logic rollback;
  } pgStrobe_t;

endpackage

// File: rtl/rx_pg_ctrl.sv
module rx_pg_ctrl
  import rx_pg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      frameStart,
  input  logic      wordValid,
  input  logic      wordLast,
  input  logic      anyFree,
  input  logic      needPage,
  output pgStrobe_t strobe,
  output logic      dropPulse
);

  rxState_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    dropPulse = 1'b0;
    case (state)
      ST_IDLE: begin
        if (frameStart && rxEnable) begin
          if (anyFree) begin
            strobe.startFrame = 1'b1;
            nextState         = ST_ACTIVE;
          end else begin
            dropPulse = 1'b1;
            nextState = ST_DROP;
          end
        end
      end
      ST_ACTIVE: begin
        if (wordValid) begin
          if (needPage && !anyFree) begin
            strobe.rollback = 1'b1;
            dropPulse       = 1'b1;
            nextState       = wordLast ? ST_IDLE : ST_DROP;
          end else begin
            strobe.writeWord = 1'b1;
            strobe.allocNext = needPage;
            if (wordLast) begin
              strobe.commit = 1'b1;
              nextState     = ST_IDLE;
            end
          end
        end
      end
      ST_DROP: begin
        if (wordValid && wordLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R1
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rxEnable) |=> (state == ST_IDLE));

  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP && !(wordValid && wordLast)) |=> (state == ST_DROP));

  // R7
  rollback_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollback |=> !strobe.writeWord);

endmodule

// File: rtl/rx_pg_data.sv
module rx_pg_data
  import rx_pg_pkg::*;
#(
  parameter int PAGES          = 32,
  parameter int WORDS_PER_PAGE = 64,
  parameter int DATA_W         = 32,
  localparam int PAGE_W        = $clog2(PAGES),
  localparam int OFF_W         = $clog2(WORDS_PER_PAGE),
  localparam int LOG_W         = PAGE_W + OFF_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pgStrobe_t               strobe,
  input  logic [DATA_W-1:0]       wordData,
  input  logic                    relValid,
  input  logic [PAGE_W-1:0]       relPage,
  input  logic [PAGE_W-1:0]       lookupPage,
  output logic [PAGE_W-1:0]       lookupNext,
  output logic                    lookupHasNext,
  output logic                    anyFree,
  output logic                    needPage,
  output logic                    memWrEn,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [DATA_W-1:0]       memData,
  output logic [LOG_W-1:0]        memLogAddr,
  output logic                    pushValid,
  output logic [PAGE_W-1:0]       pushPkt
);

  logic [PAGES-1:0]  freeMap, freeNext, frameMask;
  logic [PAGES-1:0]  hasNext;
  logic [PAGE_W-1:0] nextPtr [PAGES];
  logic [PAGE_W-1:0] curPage, pktNum, lowFree, wrPage;
  logic [LOG_W-1:0]  logAddr;
  logic              takePage;

  // Lowest-index free page: scan downward so the smallest index wins.
  always_comb begin
    lowFree = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (freeMap[i]) lowFree = PAGE_W'(i);
    end
  end

  assign anyFree  = |freeMap;
  assign needPage = (logAddr[OFF_W-1:0] == '0) && (logAddr != '0);
  assign takePage = strobe.startFrame | (strobe.writeWord & strobe.allocNext);
  assign wrPage   = needPage ? lowFree : curPage;

  assign memWrEn    = strobe.writeWord;
  assign memAddr    = {wrPage, logAddr[OFF_W-1:0]};
  assign memData    = wordData;
  assign memLogAddr = logAddr;
  assign pushValid  = strobe.commit;
  assign pushPkt    = pktNum;

  assign lookupNext    = nextPtr[lookupPage];
  assign lookupHasNext = hasNext[lookupPage];

  always_comb begin
    freeNext = freeMap;
    if (relValid) freeNext[relPage] = 1'b1;
    if (takePage) freeNext[lowFree] = 1'b0;
    if (strobe.rollback) freeNext = freeNext | frameMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMap   <= '1;
      frameMask <= '0;
      hasNext   <= '0;
      curPage   <= '0;
      pktNum    <= '0;
      logAddr   <= '0;
      for (int i = 0; i < PAGES; i++) nextPtr[i] <= '0;
    end else begin
      freeMap <= freeNext;
      if (strobe.startFrame) begin
        frameMask          <= '0;
        frameMask[lowFree] <= 1'b1;
        hasNext[lowFree]   <= 1'b0;
        pktNum             <= lowFree;
        curPage            <= lowFree;
        logAddr            <= '0;
      end
      if (strobe.writeWord) begin
        logAddr <= logAddr + LOG_W'(1);
        if (strobe.allocNext) begin
          frameMask[lowFree] <= 1'b1;
          hasNext[lowFree]   <= 1'b0;
          hasNext[curPage]   <= 1'b1;
          nextPtr[curPage]   <= lowFree;
          curPage            <= lowFree;
        end
      end
      if (strobe.rollback) frameMask <= '0;
    end
  end

  // R4
  page_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !relValid) |=> !freeMap[$past(wrPage)]);

  // R3
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !strobe.commit) |=>
      (!memWrEn || memLogAddr == $past(memLogAddr) + LOG_W'(1)));

  // R7
  rollback_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollback |=> ((freeMap & $past(frameMask)) == $past(frameMask)));

  // R2
  start_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFrame |=> (!freeMap[pktNum] && $countones(frameMask) == 1));

endmodule

// File: rtl/rx_pg_doneq.sv
module rx_pg_doneq #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic             valid,
  output logic [WIDTH-1:0] head
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPop, full;

  assign valid = (count != '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign doPop = pop && valid;
  assign head  = store[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= pushData;
        wrPtr        <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(doPop);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(push && full));

  // R8
  push_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |=> valid);

endmodule

// File: rtl/rx_page_alloc.sv
module rx_page_alloc
  import rx_pg_pkg::*;
#(
  parameter int PAGES          = 32,
  parameter int WORDS_PER_PAGE = 64,
  parameter int DATA_W         = 32,
  localparam int PAGE_W        = $clog2(PAGES),
  localparam int OFF_W         = $clog2(WORDS_PER_PAGE),
  localparam int LOG_W         = PAGE_W + OFF_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxEnable,
  input  logic                    frameStart,
  input  logic                    wordValid,
  input  logic                    wordLast,
  input  logic [DATA_W-1:0]       wordData,
  input  logic                    relValid,
  input  logic [PAGE_W-1:0]       relPage,
  input  logic [PAGE_W-1:0]       lookupPage,
  output logic [PAGE_W-1:0]       lookupNext,
  output logic                    lookupHasNext,
  output logic                    memWrEn,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [DATA_W-1:0]       memData,
  output logic [LOG_W-1:0]        memLogAddr,
  output logic                    dropPulse,
  output logic                    doneValid,
  output logic [PAGE_W-1:0]       donePkt,
  input  logic                    donePop,
  output logic                    rxIrq
);

  pgStrobe_t         strobe;
  logic              anyFree, needPage, pushValid;
  logic [PAGE_W-1:0] pushPkt;

  rx_pg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .frameStart (frameStart),
    .wordValid  (wordValid),
    .wordLast   (wordLast),
    .anyFree    (anyFree),
    .needPage   (needPage),
    .strobe     (strobe),
    .dropPulse  (dropPulse)
  );

  rx_pg_data #(
    .PAGES          (PAGES),
    .WORDS_PER_PAGE (WORDS_PER_PAGE),
    .DATA_W         (DATA_W)
  ) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wordData      (wordData),
    .relValid      (relValid),
    .relPage       (relPage),
    .lookupPage    (lookupPage),
    .lookupNext    (lookupNext),
    .lookupHasNext (lookupHasNext),
    .anyFree       (anyFree),
    .needPage      (needPage),
    .memWrEn       (memWrEn),
    .memAddr       (memAddr),
    .memData       (memData),
    .memLogAddr    (memLogAddr),
    .pushValid     (pushValid),
    .pushPkt       (pushPkt)
  );

  rx_pg_doneq #(
    .DEPTH (PAGES),
    .WIDTH (PAGE_W)
  ) u_doneq (
    .clk      (clk),
    .rstN     (rstN),
    .push     (pushValid),
    .pushData (pushPkt),
    .pop      (donePop),
    .valid    (doneValid),
    .head     (donePkt)
  );

  assign rxIrq = doneValid;

endmodule

// File: tb/rx_page_alloc_tb.sv
`timescale 1ns/1ps
module rx_page_alloc_tb;

  localparam int PAGES = 4;
  localparam int WPP   = 4;
  localparam int DW    = 32;
  localparam int PW    = $clog2(PAGES);
  localparam int OW    = $clog2(WPP);
  localparam int LW    = PW + OW + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxEnable = 1'b0, frameStart = 1'b0;
  logic          wordValid = 1'b0, wordLast = 1'b0;
  logic [DW-1:0] wordData = '0;
  logic          relValid = 1'b0;
  logic [PW-1:0] relPage = '0, lookupPage = '0;
  logic [PW-1:0] lookupNext, donePkt;
  logic          lookupHasNext, memWrEn, dropPulse, doneValid, rxIrq;
  logic          donePop = 1'b0;
  logic [PW+OW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic [LW-1:0] memLogAddr;

  rx_page_alloc #(.PAGES(PAGES), .WORDS_PER_PAGE(WPP), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameStart(frameStart),
    .wordValid(wordValid), .wordLast(wordLast), .wordData(wordData),
    .relValid(relValid), .relPage(relPage), .lookupPage(lookupPage),
    .lookupNext(lookupNext), .lookupHasNext(lookupHasNext),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .memLogAddr(memLogAddr), .dropPulse(dropPulse), .doneValid(doneValid),
    .donePkt(donePkt), .donePop(donePop), .rxIrq(rxIrq)
  );

  always #2 clk = ~clk;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  freeM [PAGES];
  int  framePages[$];
  int  expQ[$];
  int  savedB[$], savedC[$], savedD[$];
  bit  lastDropped;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest();
    for (int i = 0; i < PAGES; i++) if (freeM[i]) return i;
    return -1;
  endfunction

  task automatic runFrame(input int len, input bit en);
    int  cur;
    bit  dropped;
    @(negedge clk);
    rxEnable   = en;
    frameStart = 1'b1;
    #1;
    framePages.delete();
    if (en && lowest() < 0) begin
      chk(dropPulse == 1'b1, "R7 start overrun pulse", int'(dropPulse), 1);
      dropped = 1'b1;
    end else begin
      chk(dropPulse == 1'b0, "R7 no pulse at start", int'(dropPulse), 0);
      dropped = !en;
      if (en) begin
        cur = lowest();
        freeM[cur] = 1'b0;
        framePages.push_back(cur);
      end
    end
    for (int w = 0; w < len; w++) begin
      @(negedge clk);
      frameStart = 1'b0;
      wordValid  = 1'b1;
      wordLast   = (w == len - 1);
      wordData   = 32'hA500_0000 + len * 256 + w;
      #1;
      if (dropped) begin
        chk(memWrEn == 1'b0, en ? "R7 dropped word" : "R1 disabled word", int'(memWrEn), 0);
      end else if (w % WPP == 0 && w > 0 && lowest() < 0) begin
        chk(memWrEn == 1'b0, "R7 overrun word", int'(memWrEn), 0);
        chk(dropPulse == 1'b1, "R7 overrun pulse", int'(dropPulse), 1);
        foreach (framePages[k]) freeM[framePages[k]] = 1'b1;
        framePages.delete();
        dropped = 1'b1;
      end else begin
        if (w % WPP == 0 && w > 0) begin
          cur = lowest();
          freeM[cur] = 1'b0;
          framePages.push_back(cur);
        end
        chk(memWrEn == 1'b1, "R3 write strobe", int'(memWrEn), 1);
        chk(int'(memLogAddr) == w, "R3 logical address", int'(memLogAddr), w);
        chk(memData == wordData, "R3 data", int'(memData), int'(wordData));
        chk(int'(memAddr) == cur * WPP + w % WPP,
            (w % WPP == 0 && w > 0) ? "R5 new page address" : "R4 physical address",
            int'(memAddr), cur * WPP + w % WPP);
      end
    end
    @(negedge clk);
    frameStart = 1'b0;
    wordValid  = 1'b0;
    wordLast   = 1'b0;
    if (!dropped) expQ.push_back(framePages[0]);
    lastDropped = dropped;
  endtask

  task automatic chainCheck();
    int n;
    n = framePages.size();
    for (int i = 0; i < n; i++) begin
      lookupPage = PW'(framePages[i]);
      #1;
      chk(lookupHasNext == (i < n - 1), "R6 has-next flag", int'(lookupHasNext), int'(i < n - 1));
      if (i < n - 1)
        chk(int'(lookupNext) == framePages[i+1], "R6 next pointer", int'(lookupNext), framePages[i+1]);
    end
  endtask

  task automatic popCheck();
    int e;
    e = expQ.pop_front();
    @(negedge clk);
    #1;
    chk(doneValid == 1'b1, "R8 queue valid", int'(doneValid), 1);
    chk(rxIrq == 1'b1, "R8 interrupt", int'(rxIrq), 1);
    chk(int'(donePkt) == e, "R2/R8 packet number", int'(donePkt), e);
    donePop = 1'b1;
    @(negedge clk);
    donePop = 1'b0;
  endtask

  task automatic releasePage(input int p);
    @(negedge clk);
    relValid = 1'b1;
    relPage  = PW'(p);
    @(negedge clk);
    relValid = 1'b0;
    freeM[p] = 1'b1;
  endtask

  task automatic emptyCheck(input string req);
    #1;
    chk(doneValid == 1'b0, req, int'(doneValid), 0);
    chk(rxIrq == 1'b0, req, int'(rxIrq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGES; i++) freeM[i] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(memWrEn == 1'b0, "reset write strobe", int'(memWrEn), 0);
    chk(dropPulse == 1'b0, "reset drop pulse", int'(dropPulse), 0);
    emptyCheck("R8 reset queue empty");

    // R1: frame offered while reception is disabled
    runFrame(3, 1'b0);
    emptyCheck("R1 no completion when disabled");

    // R2..R6 sweep of every length, R7 at length 17
    for (int len = 1; len <= PAGES * WPP + 1; len++) begin
      runFrame(len, 1'b1);
      if (!lastDropped) begin
        chainCheck();
        popCheck();
        foreach (framePages[k]) releasePage(framePages[k]);
      end else begin
        emptyCheck("R7 no completion on overrun");
      end
    end

    // R9/R5 fragmented pool
    runFrame(4, 1'b1);
    runFrame(8, 1'b1);
    savedB = framePages;
    releasePage(0);
    runFrame(8, 1'b1);
    savedC = framePages;
    chainCheck();
    popCheck();
    popCheck();
    popCheck();
    emptyCheck("R8 queue drained");
    foreach (savedB[k]) releasePage(savedB[k]);
    foreach (savedC[k]) releasePage(savedC[k]);

    // R7 overrun at start, then mid-frame rollback
    runFrame(PAGES * WPP, 1'b1);
    savedD = framePages;
    runFrame(3, 1'b1);
    releasePage(2);
    runFrame(6, 1'b1);
    popCheck();
    emptyCheck("R7 dropped frames not queued");
    foreach (savedD[k]) if (savedD[k] != 2) releasePage(savedD[k]);
    runFrame(2, 1'b1);
    popCheck();
    releasePage(framePages[0]);
    emptyCheck("R8 final empty");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule